// File: doc/BRIEF.md
# Grouped GHASH Accumulator with Deferred Reduction

This block keeps a running 128-bit GHASH value and folds a stream of 128-bit data blocks into it in groups of one to four. Rather than reducing after every block, it multiplies each block of a group by the matching power of the hash key and XOR-collects the unreduced 256-bit products. The modular reduction runs once, after the group's last block. The result equals the one-block-at-a-time update GH = (GH xor b)·H.

The field is GF(2^128) with modulus x^128 + x^7 + x^2 + x + 1. Bit i of every 128-bit value is the coefficient of x^i. The key powers H^1..H^4 are computed elsewhere and held on a flat input bus. On the first beat of a group, the sender states the group length. The last beat is flagged.

A new group may start in the cycle right after a last beat. Its first block is then combined with the freshly reduced value through a bypass, so no idle cycle is needed. A synchronous clear returns the value to zero and abandons any group in progress.

Top module: `ghash_group_acc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gh` is zero and `gh_upd` is low.
- R2: The multiply-and-reduce uses modulus x^128 + x^7 + x^2 + x + 1, with bit i of a value holding the coefficient of x^i. After a group completes, `gh` equals the sequential result GH = (GH xor b)·H applied to the group's blocks in arrival order.
- R3: In a group of n blocks, `in_len` = n-1 on the first beat. The block at position j (counting from 0) is multiplied by key slot n-1-j, and only the first block is XORed with the current GH. Slot k sits on `hpow` bits [128k+127:128k] and holds H^(k+1). `in_last` is high exactly on position n-1.
- R4: `gh` changes only at the clock edge after the edge that accepts a last beat, or on clear. `gh_upd` is high for exactly the cycle that follows such an update.
- R5: Groups of 1, 2, 3 and 4 blocks all give the correct result, whether the group has an odd or an even number of blocks.
- R6: The first beat of a group may arrive in the cycle straight after the previous group's last beat. It then uses that previous group's result as GH.
- R7: Cycles with `in_valid` low inside a group have no effect on the result.
- R8: `clr` forces `gh` to zero at the next edge and keeps `gh_upd` low. It drops any partial group and any pending update. A beat presented together with `clr` is ignored.
- R9: `in_len` is sampled on the first beat of a group only. Its value on later beats has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the running value and any open group |
| in_valid | input | 1 | A data block is present this cycle |
| in_last | input | 1 | The present block closes its group |
| in_len | input | 2 | Group length minus one, read on a group's first beat |
| in_data | input | 128 | Data block |
| hpow | input | 512 | Key powers: slot k holds H^(k+1) |
| gh | output | 128 | Running GHASH value |
| gh_upd | output | 1 | `gh` took a new group result at the last edge |

## Verification
A fault in the partial-product accumulators or the pending flag does not show up until the group closes. It then appears as a wrong `gh` one cycle after the last beat. Because every later group starts from that value, the error persists until the next clear. A fault in the position counter or the key-slot selection makes a group of the affected length disagree with the sequential model. A broken bypass spoils only back-to-back groups. A fault in the update timing shows up as `gh` or `gh_upd` moving in the wrong cycle, so the comparison made on every clock exposes it at once.

// File: rtl/ghacc_pkg.sv
package ghacc_pkg;
  localparam int DW   = 128;            // field element width
  localparam int HW   = DW / 2;         // half-word for the four sub-products
  localparam int PW   = 8;              // width of the low modulus part
  localparam logic [PW-1:0] POLY_LOW = 8'h87;  // x^7 + x^2 + x + 1
  localparam int MAXG = 4;              // blocks per group, at most
  localparam int GW   = $clog2(MAXG);   // position / length field width

  typedef struct packed {
    logic [DW-1:0] hi;   // weight x^128
    logic [DW-1:0] mid;  // weight x^64
    logic [DW-1:0] lo;   // weight x^0
  } pprod_t;
endpackage

// File: rtl/ghacc_clmul.sv
module ghacc_clmul #(
  parameter int N = 64
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  logic [2*N-1:0] row [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    assign row[i] = b[i] ? ({{N{1'b0}}, a} << i) : '0;
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < N; i++) p = p ^ row[i];
  end
endmodule

// File: rtl/ghacc_pp.sv
module ghacc_pp
  import ghacc_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output pprod_t        pp
);
  logic [DW-1:0] p_hh, p_ll, p_hl, p_lh;

  ghacc_clmul #(.N(HW)) u_hh (.a(a[DW-1:HW]), .b(b[DW-1:HW]), .p(p_hh));
  ghacc_clmul #(.N(HW)) u_ll (.a(a[HW-1:0]),  .b(b[HW-1:0]),  .p(p_ll));
  ghacc_clmul #(.N(HW)) u_hl (.a(a[DW-1:HW]), .b(b[HW-1:0]),  .p(p_hl));
  ghacc_clmul #(.N(HW)) u_lh (.a(a[HW-1:0]),  .b(b[DW-1:HW]), .p(p_lh));

  always_comb begin
    pp.hi  = p_hh;
    pp.lo  = p_ll;
    pp.mid = p_hl ^ p_lh;
  end
endmodule

// File: rtl/ghacc_fold.sv
module ghacc_fold
  import ghacc_pkg::*;
(
  input  pprod_t        acc,
  input  logic [DW-1:0] tmp_hi,
  input  logic [DW-1:0] tmp_lo,
  input  logic          pending,
  output logic [DW-1:0] res
);
  localparam int EW = DW + PW - 1;   // width after the first constant fold

  logic [DW-1:0] hi_m, lo_m;
  logic [EW-1:0] f1;
  logic [PW-2:0] ovf;
  logic [DW-1:0] f2;

  // merge a still-pending pair together with the two halves of mid
  always_comb begin
    hi_m = acc.hi ^ (acc.mid >> HW) ^ (pending ? tmp_hi : '0);
    lo_m = acc.lo ^ (acc.mid << HW) ^ (pending ? tmp_lo : '0);
  end

  // first fold: x^128 is replaced by the low modulus part
  always_comb begin
    f1 = '0;
    for (int i = 0; i < PW; i++)
      if (POLY_LOW[i]) f1 = f1 ^ ({{(PW-1){1'b0}}, hi_m} << i);
    ovf = f1[EW-1:DW];
  end

  // second fold: the few bits that spilled past x^127
  always_comb begin
    f2 = '0;
    for (int i = 0; i < PW; i++)
      if (POLY_LOW[i]) f2 = f2 ^ ({{(DW-PW+1){1'b0}}, ovf} << i);
  end

  assign res = lo_m ^ f1[DW-1:0] ^ f2;
endmodule

// File: rtl/ghacc_accum.sv
module ghacc_accum
  import ghacc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          beat,
  input  logic          first,
  input  pprod_t        pp_in,
  output pprod_t        acc,
  output logic [DW-1:0] tmp_hi,
  output logic [DW-1:0] tmp_lo,
  output logic          pending
);
  pprod_t        acc_n;
  logic [DW-1:0] tmp_hi_n, tmp_lo_n;
  logic          pend_n;

  always_comb begin
    acc_n    = acc;
    tmp_hi_n = tmp_hi;
    tmp_lo_n = tmp_lo;
    pend_n   = pending;
    if (clr) begin
      pend_n = 1'b0;
    end else if (beat) begin
      if (first) begin
        acc_n  = pp_in;
        pend_n = 1'b0;
      end else begin
        acc_n.mid = acc.mid ^ pp_in.mid;
        if (pending) begin
          acc_n.hi = acc.hi ^ tmp_hi ^ pp_in.hi;
          acc_n.lo = acc.lo ^ tmp_lo ^ pp_in.lo;
          pend_n   = 1'b0;
        end else begin
          tmp_hi_n = pp_in.hi;
          tmp_lo_n = pp_in.lo;
          pend_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      tmp_hi  <= '0;
      tmp_lo  <= '0;
      pending <= 1'b0;
    end else begin
      pending <= pend_n;
      if (beat && !clr) begin
        acc    <= acc_n;
        tmp_hi <= tmp_hi_n;
        tmp_lo <= tmp_lo_n;
      end
    end
  end

  // R5: the first block of a group leaves nothing parked
  a_r5_first_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first && !clr) |=> !pending);
  // R5: each later block flips between parking and merging
  a_r5_pending_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first && !clr) |=> (pending != $past(pending)));
endmodule

// File: rtl/ghash_group_acc.sv
module ghash_group_acc
  import ghacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [GW-1:0]      in_len,
  input  logic [DW-1:0]      in_data,
  input  logic [MAXG*DW-1:0] hpow,
  output logic [DW-1:0]      gh,
  output logic               gh_upd
);
  logic [GW-1:0] pos_q, pos_n, len_q, len_n, eff_len, slot;
  logic          red_q, red_n, upd_n;
  logic [DW-1:0] gh_n, base, op_a, key, red_res;
  logic [DW-1:0] key_slot [MAXG];
  logic          beat, first;
  pprod_t        pp, acc;
  logic [DW-1:0] tmp_hi, tmp_lo;
  logic          pending;

  for (genvar k = 0; k < MAXG; k++) begin : g_slot
    assign key_slot[k] = hpow[k*DW +: DW];
  end

  // operand selection
  always_comb begin
    beat    = in_valid && !clr;
    first   = (pos_q == '0);
    eff_len = first ? in_len : len_q;
    slot    = eff_len - pos_q;
    key     = key_slot[slot];
    base    = red_q ? red_res : gh;   // bypass a reduction in flight
    op_a    = in_data ^ (first ? base : '0);
  end

  ghacc_pp u_pp (.a(op_a), .b(key), .pp(pp));

  ghacc_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .beat(beat), .first(first),
    .pp_in(pp), .acc(acc), .tmp_hi(tmp_hi), .tmp_lo(tmp_lo), .pending(pending)
  );

  ghacc_fold u_fold (
    .acc(acc), .tmp_hi(tmp_hi), .tmp_lo(tmp_lo), .pending(pending), .res(red_res)
  );

  // control next state
  always_comb begin
    pos_n = pos_q;
    len_n = len_q;
    red_n = 1'b0;
    gh_n  = gh;
    upd_n = 1'b0;
    if (clr) begin
      pos_n = '0;
      gh_n  = '0;
    end else begin
      if (red_q) begin
        gh_n  = red_res;
        upd_n = 1'b1;
      end
      if (beat) begin
        if (first) len_n = in_len;
        pos_n = in_last ? '0 : pos_q + GW'(1);
        red_n = in_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      len_q  <= '0;
      red_q  <= 1'b0;
      gh     <= '0;
      gh_upd <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      len_q  <= len_n;
      red_q  <= red_n;
      gh     <= gh_n;
      gh_upd <= upd_n;
    end
  end

  // R3: the sender closes a group exactly at the declared length
  a_r3_last_at_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |-> (in_last == (pos_q == eff_len)));
  // R4: no movement of the value outside a group close or clear
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!red_q && !clr) |=> $stable(gh));
  // R4: a closing reduction is announced on the following cycle
  a_r4_upd_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (red_q && !clr) |=> gh_upd);
  // R8: clear zeroes the value and the group position
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (gh == '0 && !gh_upd && pos_q == '0));
endmodule

// File: tb/test_ghash_group_acc.sv
module test_ghash_group_acc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_last = 1'b0;
  logic [1:0]   in_len = '0;
  logic [127:0] in_data = '0;
  logic [511:0] hpow = '0;
  logic [127:0] gh;
  logic         gh_upd;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  // model state
  logic [127:0] key_h = '0;
  logic [127:0] m_run, m_snap, m_shown;
  bit           m_rel, m_upd;

  always #2.5 clk = ~clk;   // 200 MHz

  ghash_group_acc i_ghash_group_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_last(in_last),
    .in_len(in_len), .in_data(in_data), .hpow(hpow), .gh(gh), .gh_upd(gh_upd)
  );

  function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 127; i >= 0; i--) begin
      r = {r[126:0], 1'b0} ^ (r[127] ? 128'h87 : 128'h0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural sequential model: one multiply per block, result shown after close
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = '0; m_snap = '0; m_shown = '0; m_rel = 0; m_upd = 0;
    end else if (clr) begin
      m_run = '0; m_shown = '0; m_rel = 0; m_upd = 0;
    end else begin
      m_upd = m_rel;
      if (m_rel) m_shown = m_snap;
      m_rel = 0;
      if (in_valid) begin
        m_run = gf_mul(m_run ^ in_data, key_h);
        if (in_last) begin m_rel = 1; m_snap = m_run; end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check(gh == m_shown, {cur_req, " gh"}, gh, m_shown);
      check(gh_upd == m_upd, {cur_req, " R4 gh_upd"}, {127'b0, gh_upd}, {127'b0, m_upd});
    end
  end

  task automatic set_key(input logic [127:0] h);
    logic [127:0] p = h;
    key_h = h;
    for (int k = 0; k < 4; k++) begin
      hpow[k*128 +: 128] = p;
      p = gf_mul(p, h);
    end
  endtask

  task automatic drive_beat(input logic [127:0] d, input logic [1:0] len, input bit last,
                            input bit with_clr);
    in_valid = 1'b1; in_data = d; in_len = len; in_last = last; clr = with_clr;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; clr = 1'b0;
    in_len = 2'($urandom);   // R9: junk between beats
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n blocks; gap inserts an idle cycle between beats; later in_len is junk (R9)
  task automatic send_group(input int n, input bit gap, input int pattern);
    for (int j = 0; j < n; j++) begin
      logic [127:0] d;
      case (pattern)
        1: d = '0;
        2: d = '1;
        3: d = 128'h1 << (j * 37);
        default: d = rnd128();
      endcase
      drive_beat(d, (j == 0) ? 2'(n - 1) : 2'($urandom), j == n - 1, 1'b0);
      if (gap && j < n - 1) idle(1 + ($urandom % 2));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_key(128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    repeat (2) @(negedge clk);
    cmp_on = 1'b1;
    cur_req = "R1";
    check(gh == '0 && !gh_upd, "R1 in reset", gh, '0);
    idle(1);
    rst_n = 1'b1;
    idle(1);
    check(gh == '0 && !gh_upd, "R1 after reset", gh, '0);

    // R2/R5: every group length, several data patterns
    cur_req = "R2 R5 lengths";
    for (int n = 1; n <= 4; n++) begin
      send_group(n, 1'b0, 0);
      idle(2);
    end
    cur_req = "R2 patterns";
    for (int p = 1; p <= 3; p++) begin
      send_group(4, 1'b0, p);
      idle(1);
      send_group(3, 1'b0, p);
      idle(1);
    end

    // R6: back-to-back groups with the bypass
    cur_req = "R6 back-to-back";
    for (int r = 0; r < 12; r++) send_group(1 + ($urandom % 4), 1'b0, 0);
    for (int r = 0; r < 6; r++) send_group(1, 1'b0, 0);
    idle(2);

    // R7: idle cycles inside groups
    cur_req = "R7 gaps";
    for (int r = 0; r < 8; r++) begin
      send_group(2 + ($urandom % 3), 1'b1, 0);
      idle($urandom % 2);
    end
    idle(2);

    // R3: new key, single-block groups use slot 0
    cur_req = "R3 key slots";
    set_key(rnd128());
    for (int n = 4; n >= 1; n--) begin
      send_group(n, 1'b0, 0);
      idle(1);
    end
    idle(1);

    // R8: clear in several positions
    cur_req = "R8 clear idle";
    clr = 1'b1; idle(1); clr = 1'b0;
    check(gh == '0, "R8 clear idle", gh, '0);
    send_group(3, 1'b0, 0);
    idle(2);
    cur_req = "R8 clear mid-group";
    drive_beat(rnd128(), 2'd3, 1'b0, 1'b0);
    drive_beat(rnd128(), 2'd0, 1'b0, 1'b0);
    clr = 1'b1; idle(1); clr = 1'b0;
    send_group(2, 1'b0, 0);
    idle(2);
    cur_req = "R8 clear in reduction";
    send_group(2, 1'b0, 0);
    clr = 1'b1; idle(1); clr = 1'b0;
    check(gh == '0 && !gh_upd, "R8 clear in reduction", gh, '0);
    idle(2);
    cur_req = "R8 beat with clear";
    drive_beat(rnd128(), 2'd0, 1'b1, 1'b1);
    idle(2);
    check(gh == '0 && !gh_upd, "R8 beat dropped", gh, '0);
    send_group(4, 1'b0, 0);
    idle(2);

    // long mixed run
    cur_req = "R2 R9 mixed";
    for (int r = 0; r < 40; r++) begin
      send_group(1 + ($urandom % 4), $urandom % 2, 0);
      idle($urandom % 3);
    end
    idle(3);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule